// File: doc/BRIEF.md
# Ground Loss Integrating Fault Filter

This block decides when the connection between a module's local ground and chassis ground has really opened. An analog comparator outside the block reports whether the voltage sensed on the ground-detect pin sits above its detection threshold. That result is asynchronous to the clock. The block first synchronizes it. It then feeds it into a reversible counter that integrates the comparator over time, taking one step on each sample strobe.

Samples that show an open ground move the count up, and samples that show a good ground move it back down. A short burst of noise is therefore cancelled by the good samples that follow it, and the count does not start again from zero. A fault is declared only when the count tries to pass the top of its full range. The fault then stays latched until reset or until the feature is switched off.

Detection needs both of these: the enable bit is set, and the bus is not in differential mode. In every other case the block keeps its count at zero and its fault low.

Top module: `gl_fault_filter`

## Requirements
- R1: After a synchronous reset, `count_o` is 0 and `fault_o` is 0.
- R2: `cmp_raw_i` passes through a two-stage synchronizer. A value driven before clock edge k first steers the counter at edge k+2.
- R3: While detection is armed, a strobe with an open-ground sample (synchronized comparator = 1) raises the count by one if it is below 2^CNT_W-1 (16383 with the default width of 14).
- R4: While detection is armed, a strobe with a good-ground sample (synchronized comparator = 0) lowers a nonzero count by one.
- R5: A good-ground sample while the count is 0 leaves the count at 0. The counter never wraps below zero.
- R6: On cycles with `sample_stb_i` low, the count and fault keep their values.
- R7: An open-ground strobe while the count is at its maximum sets `fault_o` on that same clock edge. The count stays at the maximum and does not wrap.
- R8: Once set, `fault_o` stays high while detection stays armed, even when later samples show a good ground.
- R9: With `gl_en_i` low, the next clock edge returns the count to 0 and clears the fault.
- R10: With `diff_mode_i` high, the next clock edge returns the count to 0 and clears the fault, and the comparator has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmp_raw_i | input | 1 | Asynchronous comparator result: 1 means the sensed voltage is above the threshold |
| gl_en_i | input | 1 | Ground-loss detection enable |
| diff_mode_i | input | 1 | Bus runs differentially: detection is unavailable |
| sample_stb_i | input | 1 | The counter steps only on cycles where this is high |
| fault_o | output | 1 | Latched ground-loss fault |
| count_o | output | CNT_W | Current integrator count |

## Verification
The hardest state to reach is the top of the counter, where the trip happens. It sits 16383 net upward steps from zero, and any good-ground sample on the way pulls the count back. The stimulus therefore holds the comparator high and strobes on every cycle for slightly more than the full range. It then checks that the fault sets on exactly the step that would overflow and that the count holds at the maximum. Next it feeds good-ground samples to show that the fault stays latched while the count falls. Alternating comparator patterns, gaps between strobes and the two-cycle synchronizer delay are covered by a cycle-accurate reference model in the bench.

// File: rtl/gl_pkg.sv
package gl_pkg;

    localparam int GL_CNT_W_DEF    = 14;
    localparam int GL_SYNC_DEF     = 2;

    // Action the integrator takes on a clock edge
    typedef enum logic [2:0] {
        ACT_CLEAR = 3'd0,
        ACT_HOLD  = 3'd1,
        ACT_UP    = 3'd2,
        ACT_DOWN  = 3'd3,
        ACT_TRIP  = 3'd4
    } gl_act_e;

    // Observation presented to the step decoder
    typedef struct packed {
        logic armed;
        logic stb;
        logic open_gnd;
        logic at_max;
        logic at_zero;
    } gl_obs_t;

    function automatic gl_act_e gl_pick(input gl_obs_t o);
        gl_act_e a;
        if (!o.armed)          a = ACT_CLEAR;
        else if (!o.stb)       a = ACT_HOLD;
        else if (o.open_gnd)   a = o.at_max ? ACT_TRIP : ACT_UP;
        else                   a = o.at_zero ? ACT_HOLD : ACT_DOWN;
        return a;
    endfunction

endpackage

// File: rtl/gl_sync.sv
module gl_sync #(
    parameter int DEPTH = gl_pkg::GL_SYNC_DEF
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [DEPTH-1:0] chain_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q[i] <= 1'b0;
                else       chain_q[i] <= (i == 0) ? d_i : chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_o = chain_q[DEPTH-1];
endmodule

// File: rtl/gl_step_decode.sv
module gl_step_decode
    import gl_pkg::*;
(
    input  logic    en_i,
    input  logic    diff_i,
    input  logic    stb_i,
    input  logic    open_i,
    input  logic    at_max_i,
    input  logic    at_zero_i,
    output gl_act_e act_o
);
    gl_obs_t obs;

    always_comb begin
        obs.armed    = en_i && !diff_i;
        obs.stb      = stb_i;
        obs.open_gnd = open_i;
        obs.at_max   = at_max_i;
        obs.at_zero  = at_zero_i;
        act_o        = gl_pick(obs);
    end
endmodule

// File: rtl/gl_integrator.sv
module gl_integrator
    import gl_pkg::*;
#(
    parameter int CNT_W = GL_CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  gl_act_e          act_i,
    input  logic             en_i,
    input  logic             diff_i,
    input  logic             stb_i,
    input  logic             open_i,
    output logic [CNT_W-1:0] count_o,
    output logic             fault_o,
    output logic             at_max_o,
    output logic             at_zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;
    logic             fault_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (act_i)
                ACT_CLEAR: begin count_q <= '0; fault_q <= 1'b0; end
                ACT_UP:    count_q <= count_q + CNT_W'(1);
                ACT_DOWN:  count_q <= count_q - CNT_W'(1);
                ACT_TRIP:  fault_q <= 1'b1;
                default:   ;
            endcase
        end
    end

    assign count_o   = count_q;
    assign fault_o   = fault_q;
    assign at_max_o  = (count_q == CNT_MAX);
    assign at_zero_o = (count_q == '0);

    logic armed;
    assign armed = en_i && !diff_i;

    assert_hold_no_strobe_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed && !stb_i) |=> ($stable(count_q) && $stable(fault_q)));

    assert_unit_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        armed |=> (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)
                   || count_q == $past(count_q) - CNT_W'(1)));

    assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed && stb_i && open_i && count_q == CNT_MAX) |=> (fault_q && count_q == CNT_MAX));

    assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed && stb_i && !open_i && count_q == '0) |=> (count_q == '0));

    assert_fault_latch_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed && fault_q) |=> fault_q);

    assert_disable_clear_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (count_q == '0 && !fault_q));

    assert_diff_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        diff_i |=> (count_q == '0 && !fault_q));
endmodule

// File: rtl/gl_fault_filter.sv
module gl_fault_filter
    import gl_pkg::*;
#(
    parameter int CNT_W      = GL_CNT_W_DEF,
    parameter int SYNC_DEPTH = GL_SYNC_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cmp_raw_i,
    input  logic             gl_en_i,
    input  logic             diff_mode_i,
    input  logic             sample_stb_i,
    output logic             fault_o,
    output logic [CNT_W-1:0] count_o
);
    logic    open_s;
    logic    at_max, at_zero;
    gl_act_e act;

    gl_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (cmp_raw_i),
        .q_o   (open_s)
    );

    gl_step_decode u_dec (
        .en_i      (gl_en_i),
        .diff_i    (diff_mode_i),
        .stb_i     (sample_stb_i),
        .open_i    (open_s),
        .at_max_i  (at_max),
        .at_zero_i (at_zero),
        .act_o     (act)
    );

    gl_integrator #(.CNT_W(CNT_W)) u_int (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .act_i     (act),
        .en_i      (gl_en_i),
        .diff_i    (diff_mode_i),
        .stb_i     (sample_stb_i),
        .open_i    (open_s),
        .count_o   (count_o),
        .fault_o   (fault_o),
        .at_max_o  (at_max),
        .at_zero_o (at_zero)
    );
endmodule

// File: tb/tb_gl_fault_filter.sv
`timescale 1ns/1ps
module tb_gl_fault_filter;
    localparam int W = 14;
    localparam logic [W-1:0] MAXV = '1;

    logic clk = 1'b0;
    logic rst = 1'b1, cmp = 1'b0, en = 1'b0, diff = 1'b0, stb = 1'b0;
    logic fault;
    logic [W-1:0] count;

    always #2.5 clk = ~clk;

    gl_fault_filter dut (
        .clk_i(clk), .rst_i(rst), .cmp_raw_i(cmp), .gl_en_i(en),
        .diff_mode_i(diff), .sample_stb_i(stb), .fault_o(fault), .count_o(count)
    );

    typedef struct {
        logic [W-1:0] cnt;
        logic         f;
        string        tag;
    } exp_t;
    exp_t q[$];

    int checks = 0, failures = 0, cyc = 0;
    logic [W-1:0] m_cnt = '0;
    logic m_f = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;
    bit done = 0;

    // Driver: apply one cycle of inputs, advance the reference model, push expected
    task automatic tick(input logic r, input logic c, input logic e, input logic d,
                        input logic s, input string tag);
        exp_t it;
        @(negedge clk);
        rst = r; cmp = c; en = e; diff = d; stb = s;
        @(posedge clk);
        if (r) begin
            m_cnt = '0; m_f = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0;
        end else begin
            if (!e || d) begin
                m_cnt = '0; m_f = 1'b0;
            end else if (s) begin
                if (m_s2) begin
                    if (m_cnt == MAXV) m_f = 1'b1;
                    else               m_cnt = m_cnt + 1'b1;
                end else if (m_cnt != '0) begin
                    m_cnt = m_cnt - 1'b1;
                end
            end
            m_s2 = m_s1;
            m_s1 = c;
        end
        it.cnt = m_cnt; it.f = m_f; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare after each edge, away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (count !== it.cnt || fault !== it.f) begin
                failures++;
                $display("FAIL %s: count=%0d fault=%0b expected count=%0d fault=%0b",
                         it.tag, count, fault, it.cnt, it.f);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, 0, "R1");
        // climb with comparator high; first steps expose sync delay
        for (int i = 0; i < 20; i++) tick(0, 1, 1, 0, 1, "R2");
        for (int i = 0; i < 10; i++) tick(0, 1, 1, 0, 1, "R3");
        // no strobe: hold
        for (int i = 0; i < 6; i++) tick(0, i[0], 1, 0, 0, "R6");
        // descend and sit at zero
        for (int i = 0; i < 25; i++) tick(0, 0, 1, 0, 1, "R4");
        for (int i = 0; i < 10; i++) tick(0, 0, 1, 0, 1, "R5");
        // glitch patterns
        for (int i = 0; i < 40; i++) tick(0, (i % 3) != 0, 1, 0, 1, "R3");
        for (int i = 0; i < 40; i++) tick(0, (i % 4) == 0, 1, 0, i[0], "R4");
        for (int i = 0; i < 40; i++) tick(0, i[1], 1, 0, 1, "R2");
        // disable clears
        tick(0, 1, 0, 0, 1, "R9");
        tick(0, 1, 0, 0, 1, "R9");
        // differential mode idle
        for (int i = 0; i < 8; i++) tick(0, 1, 1, 0, 1, "R3");
        for (int i = 0; i < 10; i++) tick(0, 1, 1, 1, 1, "R10");
        // full climb to the trip point
        for (int i = 0; i < 16400; i++) tick(0, 1, 1, 0, 1, "R7");
        // latched fault while count falls
        for (int i = 0; i < 30; i++) tick(0, 0, 1, 0, 1, "R8");
        tick(0, 0, 0, 0, 0, "R9");
        // climb again, then reset
        for (int i = 0; i < 16395; i++) tick(0, 1, 1, 0, 1, "R7");
        tick(1, 1, 1, 0, 1, "R1");
        tick(1, 0, 1, 0, 0, "R1");
        // fault cleared by differential mode
        for (int i = 0; i < 16395; i++) tick(0, 1, 1, 0, 1, "R7");
        tick(0, 1, 1, 1, 1, "R10");
        tick(0, 0, 0, 0, 0, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule